// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the processor-side register file of a VGA-style attribute controller. Software reaches it through one shared write port that carries both register indices and register data. An internal toggle decides what each write means. A write made while the toggle is clear selects a register and latches a screen-enable flag. The next write stores data into the selected register and clears the toggle. Two read paths are combinational and have no side effects. One returns the current index together with the screen-enable flag. The other returns the contents of the selected register.

The register file holds sixteen palette entries and five control registers: mode control, border (overscan) colour, colour-plane enable, horizontal pixel panning and colour select. A dedicated strobe forces the toggle back to index mode. This stands in for the status read that does the same job in a full controller. From the palette, mode and colour-select contents, the block continuously presents sixteen derived 8-bit colour-table indices. These follow any change to those registers on the cycle after the write.

Top module: `attr_regfile`

## Requirements
- R1: After synchronous reset the toggle is in index mode, the index is 0, the screen-enable flag is 0, every register reads 0 and every derived index is 0.
- R2: A write while the toggle is clear loads the index from data bits 4:0 and sets the toggle. A write while the toggle is set stores the byte into the indexed register and clears the toggle.
- R3: Bit 5 of an index write is the screen-enable flag. A data write to indices 0x00-0x0F changes the palette entry only while that flag is 0, and is silently dropped while it is 1.
- R4: The index read port returns {2'b00, screen-enable flag, index[4:0]}.
- R5: The data read port returns the stored value of the indexed register. Reading it never moves the toggle. Index map: 0x00-0x0F palette, 0x10 mode control, 0x11 border colour, 0x12 plane enable, 0x13 panning, 0x14 colour select.
- R6: The panning register keeps only bits 3:0 of the written byte and reads back zero-extended.
- R7: A data write to an index above 0x14 changes no register but still clears the toggle. A read of such an index returns 0.
- R8: The toggle-clear strobe puts the toggle in index mode. If a write arrives in the same cycle as the strobe, that write is taken as an index write.
- R9: Derived index n equals {csel[3:2], pal[n][5:0]} when mode bit 7 is 0, and {csel[3:2], csel[1:0], pal[n][3:0]} when mode bit 7 is 1. All sixteen follow on the cycle after a palette, mode or colour-select write.
- R10: Writes to indices 0x10-0x14 take effect whatever the screen-enable flag is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write byte (index byte or register data) |
| ff_clr | input | 1 | Forces the toggle to index mode |
| idx_rd | output | 8 | Index read port: flag in bit 5, index in bits 4:0 |
| dat_rd | output | 8 | Data read port: contents of the indexed register |
| dac_idx | output | 128 | Sixteen derived colour-table indices, entry n in bits 8n+7:8n |

## Verification
Assertions check on every cycle that the toggle flips on each plain write and obeys the clear strobe. They also check that a locked palette stays put, that a write beyond 0x14 leaves every register stable, and that panning captures exactly the low nibble. Only the bench scenarios can show that the read ports and the sixteen derived indices carry the right values. The bench's reference model confirms the combined effect of mode bit 7 and colour select on every derived entry, including the same-cycle strobe-and-write case.

// File: rtl/attr_pkg.sv
package attr_pkg;
    parameter int IDX_W = 5;
    parameter int DW    = 8;
    parameter int NPAL  = 16;
    parameter int PAN_W = 4;

    localparam logic [IDX_W-1:0] IX_MODE = IDX_W'(NPAL);
    localparam logic [IDX_W-1:0] IX_OVS  = IDX_W'(NPAL + 1);
    localparam logic [IDX_W-1:0] IX_CPE  = IDX_W'(NPAL + 2);
    localparam logic [IDX_W-1:0] IX_PAN  = IDX_W'(NPAL + 3);
    localparam logic [IDX_W-1:0] IX_CSEL = IDX_W'(NPAL + 4);
    localparam int EN_BIT = IDX_W;

    typedef struct packed {
        logic [NPAL-1:0][DW-1:0] pal;
        logic [DW-1:0]           mode;
        logic [DW-1:0]           ovs;
        logic [DW-1:0]           cpe;
        logic [PAN_W-1:0]        pan;
        logic [DW-1:0]           csel;
    } regs_t;

    typedef struct packed {
        logic             ff;
        logic [IDX_W-1:0] idx;
        logic             en;
    } ctl_t;
endpackage

// File: rtl/attr_index_ctl.sv
module attr_index_ctl
    import attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             ff_clr,
    output logic [IDX_W-1:0] idx_o,
    output logic             en_o,
    output logic             data_we_o
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (ff_clr || !ctl_q.ff) begin
                ctl_d.idx = wr_data[IDX_W-1:0];
                ctl_d.en  = wr_data[EN_BIT];
                ctl_d.ff  = 1'b1;
            end else begin
                ctl_d.ff  = 1'b0;
            end
        end else if (ff_clr) begin
            ctl_d.ff = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign idx_o     = ctl_q.idx;
    assign en_o      = ctl_q.en;
    assign data_we_o = wr_en && ctl_q.ff && !ff_clr;

    assert_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ff_clr) |=> (ctl_q.ff != $past(ctl_q.ff)));
    assert_idx_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ff_clr && !ctl_q.ff) |=> (ctl_q.idx == $past(wr_data[IDX_W-1:0])));
    assert_clr_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (ff_clr && !wr_en) |=> !ctl_q.ff);
    assert_clr_write_R8: assert property (@(posedge clk) disable iff (rst)
        (ff_clr && wr_en) |=> (ctl_q.ff && ctl_q.en == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank
    import attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             scr_en,
    input  logic [DW-1:0]    wdata,
    output regs_t            regs_o
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (idx < IDX_W'(NPAL)) begin
                if (!scr_en) regs_d.pal[idx[$clog2(NPAL)-1:0]] = wdata;
            end else if (idx == IX_MODE) begin
                regs_d.mode = wdata;
            end else if (idx == IX_OVS) begin
                regs_d.ovs = wdata;
            end else if (idx == IX_CPE) begin
                regs_d.cpe = wdata;
            end else if (idx == IX_PAN) begin
                regs_d.pan = wdata[PAN_W-1:0];
            end else if (idx == IX_CSEL) begin
                regs_d.csel = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    assert_pal_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (we && scr_en && idx < IDX_W'(NPAL)) |=> $stable(regs_q.pal));
    assert_pan_nibble_R6: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IX_PAN) |=> (regs_q.pan == $past(wdata[PAN_W-1:0])));
    assert_oob_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (we && idx > IX_CSEL) |=> $stable(regs_q));
    assert_ctrl_unlocked_R10: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IX_MODE) |=> (regs_q.mode == $past(wdata)));
endmodule

// File: rtl/attr_dac_map.sv
module attr_dac_map
    import attr_pkg::*;
(
    input  regs_t               regs,
    output logic [NPAL*DW-1:0]  dac_o
);
    localparam int LOW_W = DW - 2;
    localparam int NIB_W = DW - 4;

    for (genvar n = 0; n < NPAL; n++) begin : g_ent
        always_comb begin
            if (regs.mode[DW-1])
                dac_o[n*DW +: DW] = {regs.csel[3:2], regs.csel[1:0], regs.pal[n][NIB_W-1:0]};
            else
                dac_o[n*DW +: DW] = {regs.csel[3:2], regs.pal[n][LOW_W-1:0]};
        end
    end
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                ff_clr,
    output logic [DW-1:0]       idx_rd,
    output logic [DW-1:0]       dat_rd,
    output logic [NPAL*DW-1:0]  dac_idx
);
    logic [IDX_W-1:0] cur_idx;
    logic             scr_en;
    logic             data_we;
    regs_t            regs;

    attr_index_ctl u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ff_clr(ff_clr),
        .idx_o(cur_idx), .en_o(scr_en), .data_we_o(data_we)
    );

    attr_reg_bank u_bank (
        .clk(clk), .rst(rst), .we(data_we), .idx(cur_idx), .scr_en(scr_en),
        .wdata(wr_data), .regs_o(regs)
    );

    attr_dac_map u_map (.regs(regs), .dac_o(dac_idx));

    assign idx_rd = {{(DW-IDX_W-1){1'b0}}, scr_en, cur_idx};

    always_comb begin
        dat_rd = '0;
        if (cur_idx < IDX_W'(NPAL)) dat_rd = regs.pal[cur_idx[$clog2(NPAL)-1:0]];
        else if (cur_idx == IX_MODE) dat_rd = regs.mode;
        else if (cur_idx == IX_OVS)  dat_rd = regs.ovs;
        else if (cur_idx == IX_CPE)  dat_rd = regs.cpe;
        else if (cur_idx == IX_PAN)  dat_rd = {{(DW-PAN_W){1'b0}}, regs.pan};
        else if (cur_idx == IX_CSEL) dat_rd = regs.csel;
    end
endmodule

// File: tb/attr_regfile_bench.sv
module attr_regfile_bench;
    logic clk = 0;
    logic rst = 1;
    logic wr_en = 0;
    logic [7:0] wr_data = 0;
    logic ff_clr = 0;
    logic [7:0] idx_rd, dat_rd;
    logic [127:0] dac_idx;

    int runs = 0;
    int fails = 0;

    always #5 clk = ~clk;

    attr_regfile u_attr_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ff_clr(ff_clr),
        .idx_rd(idx_rd), .dat_rd(dat_rd), .dac_idx(dac_idx)
    );

    // behavioural reference model
    int m_pal[16];
    int m_mode, m_ovs, m_cpe, m_pan, m_csel, m_idx;
    bit m_ff, m_en;

    function automatic int exp_dat();
        if (m_idx < 16) return m_pal[m_idx];
        case (m_idx)
            16: return m_mode;
            17: return m_ovs;
            18: return m_cpe;
            19: return m_pan;
            20: return m_csel;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_dac(int n);
        if (m_mode & 8'h80) return ((m_csel & 8'h0F) << 4) | (m_pal[n] & 8'h0F);
        return ((m_csel & 8'h0C) << 4) | (m_pal[n] & 8'h3F);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_pal[i] = 0;
        m_mode = 0; m_ovs = 0; m_cpe = 0; m_pan = 0; m_csel = 0;
        m_idx = 0; m_ff = 0; m_en = 0;
    endtask

    task automatic model_edge(bit we, int d, bit clr);
        if (we && (clr || !m_ff)) begin
            m_idx = d & 8'h1F; m_en = (d >> 5) & 1; m_ff = 1;
        end else if (we) begin
            m_ff = 0;
            if (m_idx < 16) begin
                if (!m_en) m_pal[m_idx] = d;
            end else if (m_idx == 16) m_mode = d;
            else if (m_idx == 17) m_ovs = d;
            else if (m_idx == 18) m_cpe = d;
            else if (m_idx == 19) m_pan = d & 8'h0F;
            else if (m_idx == 20) m_csel = d;
        end else if (clr) m_ff = 0;
    endtask

    task automatic check(string req, int act, int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R4 index read", idx_rd, (int'(m_en) << 5) | m_idx);
        check("R5 data read", dat_rd, exp_dat());
        for (int n = 0; n < 16; n++)
            check("R9 derived index", dac_idx[n*8 +: 8], exp_dac(n));
    endtask

    task automatic step(bit we, int d, bit clr);
        @(negedge clk);
        wr_en = we; wr_data = d[7:0]; ff_clr = clr;
        @(posedge clk);
        model_edge(we, d, clr);
        @(negedge clk);
        wr_en = 0; ff_clr = 0;
        compare_all();
    endtask

    task automatic wr(int d);
        step(1, d, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 index read", idx_rd, 0);
        check("R1 data read", dat_rd, 0);
        check("R1 derived", int'(dac_idx == '0), 1);
        compare_all();

        // R2: index then data
        wr(8'h03); wr(8'h2A);
        check("R2 palette 3", dat_rd, 8'h2A);
        // R5: idle cycles do not toggle; next write is index
        step(0, 0, 0); step(0, 0, 0);
        wr(8'h04); wr(8'h3C);
        check("R5 no toggle on read", dat_rd, 8'h3C);

        // R3: locked palette
        wr(8'h25); wr(8'h11);
        check("R3 locked write dropped", dat_rd, 0);
        check("R4 flag visible", idx_rd, 8'h25);

        // R10: control registers with flag set
        wr(8'h30); wr(8'h80);
        check("R10 mode written", dat_rd, 8'h80);
        check("R9 mode7 entry3", dac_idx[3*8 +: 8], 8'h0A);
        wr(8'h34); wr(8'h0F);
        check("R9 csel entry3", dac_idx[3*8 +: 8], 8'hFA);
        wr(8'h30); wr(8'h00);
        check("R9 mode7 clear entry3", dac_idx[3*8 +: 8], 8'hEA);

        // R6: panning nibble
        wr(8'h33); wr(8'hFB);
        check("R6 panning", dat_rd, 8'h0B);

        // R7: out of range index
        wr(8'h35); wr(8'h77);
        check("R7 oob read", dat_rd, 0);
        wr(8'h1F);
        check("R7 oob read 1F", dat_rd, 0);
        wr(8'h01);
        check("R7 toggle cleared", dat_rd, 0);
        wr(8'h31);
        check("R7 border untouched", dat_rd, 0);

        // R8: clear strobe
        step(0, 0, 1);
        wr(8'h12);
        check("R8 index after clear", idx_rd, 8'h12);
        wr(8'h55);
        check("R8 plane enable", dat_rd, 8'h55);
        wr(8'h11);
        step(1, 8'h02, 1);
        check("R8 same-cycle write is index", idx_rd, 8'h02);
        wr(8'h19);
        check("R8 data after clear", dat_rd, 8'h19);

        // sweep palette with both mode settings
        for (int i = 0; i < 16; i++) begin
            wr(i); wr((i * 37 + 5) & 8'hFF);
        end
        wr(8'h14); wr(8'h06);
        wr(8'h10); wr(8'h81);
        wr(8'h10); wr(8'h01);
        wr(8'h20); wr(8'h77);
        check("R3 locked sweep entry0", dac_idx[7:0], exp_dac(0));

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule